// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block creates the two pulse trains that a tuner's phase comparator needs. The first is the divided local-oscillator train (fSIG). The second is the reference train (fREF), derived from the crystal. All logic runs on one system clock. Each incoming oscillator or crystal cycle arrives as a one-clock tick strobe.

The 16-bit ratio word N is split into two fields. The low four bits are the swallow count S, and the upper twelve bits are the main count M. A five-bit prescaler counter divides by 17 while swallow periods remain and by 16 after that, so one fSIG pulse appears for every 16·M + S ticks. The smallest legal word is 528. A smaller word is refused and flagged. The ratio is picked up only at a cycle boundary, so a retune never shortens or stretches a cycle that has already started.

A band bit picks the FM or the AM oscillator tick. A crystal-select pair together with a 3-bit step code picks the reference ratio. Any combination with no defined step holds fREF low and raises a flag.

Top module: `pswallow_synth`

## Requirements
- R1: Bits n_word[3:0] are the swallow count S and n_word[15:4] are the main count M. Once a ratio is in force, exactly one fsig_pulse is produced for every 16·M + S ticks of the selected oscillator. This holds for every S from 0 to 15, up to N = 65535.
- R2: With band_am = 0, only fm_tick advances the divider. With band_am = 1, only am_tick advances it. Ticks on the unselected input have no effect on pulse spacing.
- R3: A new n_word is adopted only at the edge that ends the current cycle. The cycle in progress when the word changes completes with the old ratio.
- R4: When n_word < 528, ratio_err is 1 in the same cycle and the word is not adopted; the ratio already in force continues. If no legal word has been seen since reset, the ratio in force is 528.
- R5: fsig_pulse is high for exactly one clock. That clock is the one following the edge that samples the tick ending the cycle.
- R6: xtal_sel = 2'b00 (low crystal) with step_code 3'd1, 3'd4 or 3'd7 gives one fref_pulse per 205, 1025 or 10250 xtal ticks respectively. xtal_sel = 2'b10 (high crystal) with step_code 3'd1 or 3'd5 gives one pulse per 207 or 1150 ticks. In step_code, bit 0 is the coarse-step bit and bit 2 is the fine-step bit.
- R7: Every other combination of xtal_sel and step_code, including any xtal_sel with bit 0 set, drives ref_err to 1 and keeps fref_pulse at 0.
- R8: After an undefined combination is replaced by a defined one, the reference count starts from zero. The first fref_pulse follows exactly one full ratio of ticks, counted from the first cycle in which the defined combination is applied.
- R9: During reset both pulse outputs are 0. After reset is released, the divider counts its first cycle from the first tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fm_tick | input | 1 | One strobe per FM oscillator cycle |
| am_tick | input | 1 | One strobe per AM oscillator cycle |
| xtal_tick | input | 1 | One strobe per crystal cycle |
| band_am | input | 1 | 0 selects fm_tick, 1 selects am_tick |
| n_word | input | 16 | Ratio word: [3:0] swallow count, [15:4] main count |
| xtal_sel | input | 2 | Crystal choice: 2'b00 low, 2'b10 high |
| step_code | input | 3 | Reference step code |
| fsig_pulse | output | 1 | Divided oscillator pulse |
| fref_pulse | output | 1 | Reference pulse |
| ratio_err | output | 1 | n_word below 528 |
| ref_err | output | 1 | Undefined crystal/step combination |

## Verification
The hardest case to reach from the ports is a ratio word that changes in the middle of a cycle. Seeing that the old ratio still finishes requires the change to fall at a known tick position inside a cycle whose start is itself known. The stimulus therefore locks onto an observed fsig_pulse, counts 100 ticks, and only then rewrites n_word. It then measures the two following gaps in ticks. Ratios with S = 15 and N = 65535 are also measured this way. The AM band runs with sparse ticks while the FM input toggles on every clock, so any leak from the unselected input would change the measured gaps.

The FSM states are as follows. DV_IDLE loads the ratio once after reset. From there it moves to DV_SWALLOW when S ≠ 0, or to DV_PLAIN when S = 0. DV_SWALLOW falls to DV_PLAIN when the last swallow period ends. The end of the last main period reloads the ratio and re-enters DV_SWALLOW or DV_PLAIN. The reference side moves between RF_HALT (undefined code) and RF_COUNT (defined code).

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [1:0] {
        DV_IDLE    = 2'd0,
        DV_SWALLOW = 2'd1,
        DV_PLAIN   = 2'd2
    } div_state_t;

    typedef enum logic {
        RF_HALT  = 1'b0,
        RF_COUNT = 1'b1
    } ref_state_t;

    localparam logic [1:0] XT_LOW  = 2'b00;
    localparam logic [1:0] XT_HIGH = 2'b10;

    localparam logic [2:0] STEP_WIDE = 3'd1;
    localparam logic [2:0] STEP_MID  = 3'd4;
    localparam logic [2:0] STEP_ALT  = 3'd5;
    localparam logic [2:0] STEP_FINE = 3'd7;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psd_ratio_div.sv
module psd_ratio_div
    import psd_pkg::*;
#(
    parameter int NW    = 16,
    parameter int SW    = 4,
    parameter int N_MIN = 528
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo_tick,
    input  logic [NW-1:0] n_word,
    output logic          fsig_pulse,
    output logic          ratio_err
);
    localparam int MW       = NW - SW;
    localparam int PW       = SW + 1;
    localparam int BASE_MOD = 1 << SW;
    localparam logic [PW-1:0] LAST_PLAIN = PW'(BASE_MOD - 1);
    localparam logic [PW-1:0] LAST_SWAL  = PW'(BASE_MOD);

    div_state_t    state_q, state_d;
    logic [PW-1:0] pcnt_q, pcnt_d;
    logic [MW-1:0] mcnt_q, mcnt_d;
    logic [SW-1:0] scnt_q, scnt_d;
    logic [NW-1:0] act_n_q, act_n_d;
    logic [NW-1:0] nxt_n;
    logic          ratio_ok;
    logic          do_load;
    logic          end_cycle;
    logic          period_end;

    assign ratio_ok  = (n_word >= NW'(N_MIN));
    assign ratio_err = ~ratio_ok;
    assign nxt_n     = ratio_ok ? n_word : act_n_q;

    assign period_end = (pcnt_q == ((state_q == DV_SWALLOW) ? LAST_SWAL : LAST_PLAIN));

    always_comb begin
        state_d   = state_q;
        pcnt_d    = pcnt_q;
        mcnt_d    = mcnt_q;
        scnt_d    = scnt_q;
        act_n_d   = act_n_q;
        do_load   = 1'b0;
        end_cycle = 1'b0;
        unique case (state_q)
            DV_IDLE: do_load = 1'b1;
            DV_SWALLOW, DV_PLAIN: begin
                if (lo_tick) begin
                    if (period_end) begin
                        pcnt_d = '0;
                        if (mcnt_q == MW'(1)) begin
                            end_cycle = 1'b1;
                            do_load   = 1'b1;
                        end else begin
                            mcnt_d = mcnt_q - MW'(1);
                            if (state_q == DV_SWALLOW) begin
                                scnt_d = scnt_q - SW'(1);
                                if (scnt_q == SW'(1)) state_d = DV_PLAIN;
                            end
                        end
                    end else begin
                        pcnt_d = pcnt_q + PW'(1);
                    end
                end
            end
            default: state_d = DV_IDLE;
        endcase
        if (do_load) begin
            act_n_d = nxt_n;
            mcnt_d  = nxt_n[NW-1:SW];
            scnt_d  = nxt_n[SW-1:0];
            pcnt_d  = '0;
            state_d = (nxt_n[SW-1:0] != '0) ? DV_SWALLOW : DV_PLAIN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DV_IDLE;
            pcnt_q  <= '0;
            mcnt_q  <= '0;
            scnt_q  <= '0;
            act_n_q <= NW'(N_MIN);
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
            mcnt_q  <= mcnt_d;
            scnt_q  <= scnt_d;
            act_n_q <= act_n_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsig_pulse <= 1'b0;
        else        fsig_pulse <= end_cycle;
    end

    assert_swallow_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DV_SWALLOW) |-> (scnt_q != '0));

    assert_boundary_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_n_q) && $past(state_q) != DV_IDLE) |-> fsig_pulse);

    assert_legal_ratio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_n_q >= NW'(N_MIN));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fsig_pulse |=> !fsig_pulse);

endmodule

// File: rtl/psd_ref_table.sv
module psd_ref_table
    import psd_pkg::*;
#(
    parameter int RW            = 14,
    parameter int RATIO_LO_WIDE = 205,
    parameter int RATIO_LO_MID  = 1025,
    parameter int RATIO_LO_FINE = 10250,
    parameter int RATIO_HI_WIDE = 207,
    parameter int RATIO_HI_ALT  = 1150
) (
    input  logic [1:0]    xtal_sel,
    input  logic [2:0]    step_code,
    output logic [RW-1:0] ratio,
    output logic          ok
);
    always_comb begin
        ratio = '0;
        ok    = 1'b1;
        case ({xtal_sel, step_code})
            {XT_LOW,  STEP_WIDE}: ratio = RW'(RATIO_LO_WIDE);
            {XT_LOW,  STEP_MID }: ratio = RW'(RATIO_LO_MID);
            {XT_LOW,  STEP_FINE}: ratio = RW'(RATIO_LO_FINE);
            {XT_HIGH, STEP_WIDE}: ratio = RW'(RATIO_HI_WIDE);
            {XT_HIGH, STEP_ALT }: ratio = RW'(RATIO_HI_ALT);
            default:              ok    = 1'b0;
        endcase
    end
endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div
    import psd_pkg::*;
#(
    parameter int RW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_tick,
    input  logic [RW-1:0] ratio,
    input  logic          ok,
    output logic          fref_pulse
);
    ref_state_t    state_q;
    logic [RW-1:0] rcnt_q;
    logic          wrap;

    assign wrap = (rcnt_q >= ratio - RW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RF_HALT;
            rcnt_q  <= '0;
        end else begin
            unique case (state_q)
                RF_HALT:  state_q <= ok ? RF_COUNT : RF_HALT;
                RF_COUNT: state_q <= ok ? RF_COUNT : RF_HALT;
                default:  state_q <= RF_HALT;
            endcase
            if (!ok)         rcnt_q <= '0;
            else if (x_tick) rcnt_q <= wrap ? '0 : rcnt_q + RW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fref_pulse <= 1'b0;
        else        fref_pulse <= ok && x_tick && wrap;
    end

    assert_ref_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fref_pulse |=> !fref_pulse);

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |=> !fref_pulse);

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RF_HALT) |-> (rcnt_q == '0));

endmodule

// File: rtl/pswallow_synth.sv
module pswallow_synth
    import psd_pkg::*;
#(
    parameter int NW            = 16,
    parameter int SW            = 4,
    parameter int N_MIN         = 528,
    parameter int RATIO_LO_WIDE = 205,
    parameter int RATIO_LO_MID  = 1025,
    parameter int RATIO_LO_FINE = 10250,
    parameter int RATIO_HI_WIDE = 207,
    parameter int RATIO_HI_ALT  = 1150
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fm_tick,
    input  logic          am_tick,
    input  logic          xtal_tick,
    input  logic          band_am,
    input  logic [NW-1:0] n_word,
    input  logic [1:0]    xtal_sel,
    input  logic [2:0]    step_code,
    output logic          fsig_pulse,
    output logic          fref_pulse,
    output logic          ratio_err,
    output logic          ref_err
);
    localparam int RMAX = imax(imax(imax(RATIO_LO_WIDE, RATIO_LO_MID), imax(RATIO_LO_FINE, RATIO_HI_WIDE)), RATIO_HI_ALT);
    localparam int RW   = $clog2(RMAX + 1);

    logic          lo_tick;
    logic [RW-1:0] ref_ratio;
    logic          ref_ok;

    assign lo_tick = band_am ? am_tick : fm_tick;
    assign ref_err = ~ref_ok;

    psd_ratio_div #(.NW(NW), .SW(SW), .N_MIN(N_MIN)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_tick    (lo_tick),
        .n_word     (n_word),
        .fsig_pulse (fsig_pulse),
        .ratio_err  (ratio_err)
    );

    psd_ref_table #(
        .RW(RW), .RATIO_LO_WIDE(RATIO_LO_WIDE), .RATIO_LO_MID(RATIO_LO_MID),
        .RATIO_LO_FINE(RATIO_LO_FINE), .RATIO_HI_WIDE(RATIO_HI_WIDE), .RATIO_HI_ALT(RATIO_HI_ALT)
    ) u_tab (
        .xtal_sel  (xtal_sel),
        .step_code (step_code),
        .ratio     (ref_ratio),
        .ok        (ref_ok)
    );

    psd_ref_div #(.RW(RW)) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .x_tick     (xtal_tick),
        .ratio      (ref_ratio),
        .ok         (ref_ok),
        .fref_pulse (fref_pulse)
    );

endmodule

// File: tb/pswallow_synth_bench.sv
module pswallow_synth_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fm_tick = 1'b0, am_tick = 1'b0, xtal_tick = 1'b0, band_am = 1'b0;
    logic [15:0] n_word = 16'd0;
    logic [1:0]  xtal_sel = 2'b00;
    logic [2:0]  step_code = 3'd2;
    logic        fsig_pulse, fref_pulse, ratio_err, ref_err;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pswallow_synth u_pswallow_synth (
        .clk(clk), .rst_n(rst_n), .fm_tick(fm_tick), .am_tick(am_tick),
        .xtal_tick(xtal_tick), .band_am(band_am), .n_word(n_word),
        .xtal_sel(xtal_sel), .step_code(step_code), .fsig_pulse(fsig_pulse),
        .fref_pulse(fref_pulse), .ratio_err(ratio_err), .ref_err(ref_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sync on one fsig pulse, then measure `gaps` pulse spacings in selected ticks.
    // sparse=1: selected tick every third clock, unselected tick every clock.
    task automatic div_gaps(input int n_exp, input int gaps, input bit am, input bit sparse, input string req);
        int cnt = 0;
        int got = 0;
        int cyc = 0;
        bit synced = 0;
        bit sel;
        band_am = am;
        while (got < gaps) begin
            @(negedge clk);
            cyc++;
            fm_tick = 1'b0;
            am_tick = 1'b0;
            if (fsig_pulse) begin
                if (synced) begin
                    chk(cnt == n_exp, req, cnt, n_exp);
                    got++;
                end
                synced = 1;
                cnt = 0;
            end
            if (got < gaps) begin
                sel = sparse ? (cyc % 3 == 0) : 1'b1;
                if (am) begin am_tick = sel; fm_tick = sparse; end
                else    begin fm_tick = sel; am_tick = sparse; end
                if (sel) cnt++;
            end
        end
        fm_tick = 1'b0;
        am_tick = 1'b0;
    endtask

    task automatic ref_gaps(input logic [1:0] xs, input logic [2:0] code, input int r_exp, input int gaps, input string req);
        int cnt = 0;
        int got = 0;
        bit synced = 0;
        xtal_sel = xs;
        step_code = code;
        while (got < gaps) begin
            @(negedge clk);
            xtal_tick = 1'b0;
            if (fref_pulse) begin
                if (synced) begin
                    chk(cnt == r_exp, req, cnt, r_exp);
                    got++;
                end
                synced = 1;
                cnt = 0;
            end
            if (got < gaps) begin
                xtal_tick = 1'b1;
                cnt++;
            end
        end
        chk(ref_err == 1'b0, "R6 ref_err low on defined code", ref_err, 0);
        xtal_tick = 1'b0;
    endtask

    initial begin
        int cnt;
        bit seen;
        int hits;
        int nlist[7] = '{528, 529, 543, 544, 560, 1000, 4097};

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(fsig_pulse == 1'b0, "R9 fsig low in reset", fsig_pulse, 0);
        chk(fref_pulse == 1'b0, "R9 fref low in reset", fref_pulse, 0);
        rst_n = 1'b1;

        // R4 / R9: illegal word from reset -> ratio 528, first cycle counted from first tick
        chk(ratio_err == 1'b1, "R4 ratio_err on n_word=0", ratio_err, 1);
        cnt = 0; seen = 0;
        while (!seen) begin
            @(negedge clk);
            fm_tick = 1'b0;
            if (fsig_pulse) begin
                chk(cnt == 528, "R9 first cycle after reset", cnt, 528);
                seen = 1;
            end else begin
                fm_tick = 1'b1;
                cnt++;
            end
        end

        // R1 / R5: sweep of ratios over swallow edge values, FM band, dense ticks
        foreach (nlist[i]) begin
            n_word = 16'(nlist[i]);
            div_gaps(nlist[i], 2, 1'b0, 1'b0, "R1 divide ratio FM");
        end
        chk(ratio_err == 1'b0, "R4 ratio_err low on legal word", ratio_err, 0);

        // R2: AM band, sparse selected ticks, FM noise every clock
        n_word = 16'd529;
        div_gaps(529, 2, 1'b1, 1'b1, "R2 AM band ignores fm_tick");
        n_word = 16'd543;
        div_gaps(543, 2, 1'b1, 1'b1, "R2 AM band S=15");
        // R2: FM band, sparse, AM noise
        n_word = 16'd600;
        div_gaps(600, 2, 1'b0, 1'b1, "R2 FM band ignores am_tick");

        // R3: word changed 100 ticks into a 600 cycle
        cnt = 0; seen = 0;
        while (!seen) begin
            @(negedge clk);
            fm_tick = 1'b0;
            if (fsig_pulse) begin
                chk(cnt == 600, "R3 old ratio completes", cnt, 600);
                seen = 1;
            end else begin
                fm_tick = 1'b1;
                cnt++;
                if (cnt == 100) n_word = 16'd900;
            end
        end
        div_gaps(900, 1, 1'b0, 1'b0, "R3 new ratio next cycle");

        // R4: illegal word is refused, previous ratio held
        n_word = 16'd527;
        @(negedge clk);
        chk(ratio_err == 1'b1, "R4 ratio_err on 527", ratio_err, 1);
        div_gaps(900, 1, 1'b0, 1'b0, "R4 ratio held on illegal word");

        // R1: largest ratio
        n_word = 16'hFFFF;
        div_gaps(65535, 1, 1'b0, 1'b0, "R1 ratio 65535");

        // R6: reference ratios
        ref_gaps(2'b00, 3'd1, 205, 2, "R6 low crystal wide step");
        ref_gaps(2'b00, 3'd4, 1025, 2, "R6 low crystal mid step");
        ref_gaps(2'b10, 3'd1, 207, 2, "R6 high crystal wide step");
        ref_gaps(2'b10, 3'd5, 1150, 2, "R6 high crystal alt step");
        ref_gaps(2'b00, 3'd7, 10250, 1, "R6 low crystal fine step");

        // R7: undefined combinations hold fref low
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: begin xtal_sel = 2'b00; step_code = 3'd5; end
                1: begin xtal_sel = 2'b10; step_code = 3'd7; end
                2: begin xtal_sel = 2'b01; step_code = 3'd1; end
                default: begin xtal_sel = 2'b11; step_code = 3'd0; end
            endcase
            hits = 0;
            for (int c = 0; c < 300; c++) begin
                @(negedge clk);
                xtal_tick = 1'b1;
                if (fref_pulse) hits++;
            end
            chk(ref_err == 1'b1, "R7 ref_err on undefined code", ref_err, 1);
            chk(hits == 0, "R7 no fref on undefined code", hits, 0);
        end

        // R8: restart from zero when a defined code returns
        @(negedge clk);
        xtal_sel = 2'b00; step_code = 3'd1; xtal_tick = 1'b1;
        cnt = 1; seen = 0;
        while (!seen) begin
            @(negedge clk);
            xtal_tick = 1'b0;
            if (fref_pulse) begin
                chk(cnt == 205, "R8 first reference after restart", cnt, 205);
                seen = 1;
            end else begin
                xtal_tick = 1'b1;
                cnt++;
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule